// File: doc/BRIEF.md
# Audio Sample FIFO Port

This block is the sample store for one direction of a serial audio port. On one side sits a word-wide register port used by software. On the other side sits a serializer strobe that moves one 24-bit sample per request. In the transmit build, software writes samples into the data register and the serializer drains them. In the receive build, the serializer fills the store and software drains it through the same data register.

The storage is a fixed pool of sample slots. The active channel count divides this pool evenly, so each channel gets a fixed depth. Software sees the fill level as complete frames, where a frame is one sample for every active channel. The store keeps sticky overflow and underflow flags. It can raise an interrupt request around the half-level mark, and software can flush it from the control register.

Registers sit at word addresses 0 (sample data), 1 (control) and 2 (status). Address 3 reads as zero. In the transmit build, reads of the data address return zero and have no effect. In the receive build, writes to the data address have no effect. The serializer strobe and read data are registered, and the result appears one cycle after the request.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset, the status register reads 0, the control register reads a channel count of 1 with the interrupt enable clear, and `irq` is low.
- R2: Only bits [23:0] of a sample written over the bus are kept. Bits [31:24] are dropped, and a sample comes back with zeros above bit 23. A 16-bit sample held in bits [23:8] keeps its zero low byte.
- R3: Samples leave the store in the order they entered it.
- R4: The store holds at most depth×channels samples. Depth per channel is 256 for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8 (with the default 256 slots).
- R5: A push when the store is at capacity is dropped and sets the overflow flag, status bit 4.
- R6: A pop from an empty store returns zero and sets the underflow flag, status bit 0.
- R7: Both flags stay set until software writes 1 to the matching status bit at address 2. Writing 0 leaves them alone.
- R8: Status bits [16:8] give the number of complete frames held, which is the floor of the samples held divided by the channel count.
- R9: Writing control bit 0 as 1 empties the store. The fill level then reads 0, and later pops see the store as empty.
- R10: Control bit 20 enables `irq`. In the transmit build, `irq` is high while the frame fill is at or below half the per-channel depth. In the receive build, it is high while the frame fill is at or above that half.
- R11: Control bits [11:8] hold the channel count. A value of 0 or above 8 is ignored and the old count is kept. A legal value that differs from the current count also empties the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Word address: 0 data, 1 control, 2 status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| serReq | input | 1 | Serializer strobe: pop (transmit) or push (receive) |
| serIn | input | 24 | Sample pushed by the serializer (receive build) |
| serOut | output | 24 | Sample popped for the serializer (transmit build), registered |
| irq | output | 1 | Half-level interrupt request |

## Verification
The bench fills the store to exactly its capacity at odd channel counts such as 3 and 5. A design that took the full pool as capacity would accept extra samples and never flag overflow. Partial frames are checked: with 3 channels and 4 samples held, the fill must read 1, and a design counting words would report 4. The bench writes illegal channel values and switches between legal counts. A design that took the illegal value would divide by zero or change depth, and one that kept stale data after a change would replay it. It also drives the receive build across its half level, pops an empty store, and clears flags by writing 1, so an inverted threshold, a non-zero underflow sample or a clear-on-read flag each show up at the ports.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CH_W = 4;
  localparam int MAX_CH = 8;

  localparam int CTRL_FLUSH_BIT = 0;
  localparam int CTRL_CH_LSB = 8;
  localparam int CTRL_HALF_BIT = 20;
  localparam int STAT_UN_BIT = 0;
  localparam int STAT_OV_BIT = 4;
  localparam int STAT_FILL_LSB = 8;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic [SAMPLE_W-1:0] pushData;
  } fifoCmd_t;

  // Slots available to each channel for a given channel count.
  function automatic int unsigned chanDepth(input int unsigned slots, input logic [CH_W-1:0] ch);
    if (ch <= 4'd1) return slots;
    else if (ch == 4'd2) return slots >> 1;
    else if (ch <= 4'd4) return slots >> 2;
    else return slots >> 3;
  endfunction
endpackage

// File: rtl/asf_datapath.sv
module asf_datapath
  import asf_pkg::*;
#(
  parameter int SLOTS = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fifoCmd_t                      cmd,
  input  logic [CH_W-1:0]               chanCount,
  output logic [SAMPLE_W-1:0]           headData,
  output logic [$clog2(SLOTS+1)-1:0]    frameFill,
  output logic                          full,
  output logic                          empty
);
  localparam int PTR_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [SAMPLE_W-1:0] mem [SLOTS];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] wordCount;
  logic [CNT_W-1:0] capWords;

  // Sample storage: no reset needed, the count guards what is valid.
  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.flush) mem[wrPtr] <= cmd.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      wordCount <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + 1'b1;
      if (cmd.pop) rdPtr <= rdPtr + 1'b1;
      case ({cmd.push, cmd.pop})
        2'b10: wordCount <= wordCount + 1'b1;
        2'b01: wordCount <= wordCount - 1'b1;
        default: wordCount <= wordCount;
      endcase
    end
  end

  assign capWords = CNT_W'(chanDepth(SLOTS, chanCount) * int'(chanCount));
  assign full = (wordCount >= capWords);
  assign empty = (wordCount == '0);
  assign headData = mem[rdPtr];
  // Only whole frames count toward the reported fill.
  assign frameFill = wordCount / CNT_W'(chanCount);
endmodule

// File: rtl/asf_control.sv
module asf_control
  import asf_pkg::*;
#(
  parameter int SLOTS = 256,
  parameter bit IS_TX = 1'b1,
  parameter int BUS_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic                          regRdEn,
  input  logic [1:0]                    regAddr,
  input  logic [BUS_W-1:0]              regWrData,
  output logic [BUS_W-1:0]              regRdData,
  input  logic                          serReq,
  input  logic [SAMPLE_W-1:0]           serIn,
  output logic [SAMPLE_W-1:0]           serOut,
  input  logic                          full,
  input  logic                          empty,
  input  logic [SAMPLE_W-1:0]           headData,
  input  logic [$clog2(SLOTS+1)-1:0]    frameFill,
  output fifoCmd_t                      cmd,
  output logic [CH_W-1:0]               chanCount,
  output logic                          halfEn,
  output logic                          ovFlag,
  output logic                          unFlag,
  output logic                          irq
);
  localparam int FILL_W = $clog2(SLOTS + 1);

  regAddr_e addrSel;
  logic dataWr, dataRd, ctrlWr, statWr;
  logic pushReq, popReq;
  logic [SAMPLE_W-1:0] pushSample;
  logic [SAMPLE_W-1:0] busPopValue;
  logic [CH_W-1:0] newCh;
  logic chLegal, flushNow;
  logic [FILL_W-1:0] halfLevel;
  logic [BUS_W-1:0] readMux;

  assign addrSel = regAddr_e'(regAddr);
  assign dataWr = regWrEn && (addrSel == ADDR_DATA);
  assign dataRd = regRdEn && (addrSel == ADDR_DATA);
  assign ctrlWr = regWrEn && (addrSel == ADDR_CTRL);
  assign statWr = regWrEn && (addrSel == ADDR_STAT);

  // Direction picks which side pushes and which side pops.
  generate
    if (IS_TX) begin : g_tx
      assign pushReq = dataWr;
      assign popReq = serReq;
      assign pushSample = regWrData[SAMPLE_W-1:0];
      assign busPopValue = '0;
      always_ff @(posedge clk) begin
        if (!rstN) serOut <= '0;
        else if (serReq) serOut <= empty ? '0 : headData;
      end
    end else begin : g_rx
      assign pushReq = serReq;
      assign popReq = dataRd;
      assign pushSample = serIn;
      assign busPopValue = empty ? '0 : headData;
      assign serOut = '0;
    end
  endgenerate

  assign newCh = regWrData[CTRL_CH_LSB +: CH_W];
  assign chLegal = (newCh >= 4'd1) && (int'(newCh) <= MAX_CH);
  assign flushNow = ctrlWr && (regWrData[CTRL_FLUSH_BIT] || (chLegal && newCh != chanCount));

  assign cmd.push = pushReq && !full;
  assign cmd.pop = popReq && !empty;
  assign cmd.flush = flushNow;
  assign cmd.pushData = pushSample;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanCount <= 4'd1;
      halfEn <= 1'b0;
    end else if (ctrlWr) begin
      halfEn <= regWrData[CTRL_HALF_BIT];
      if (chLegal) chanCount <= newCh;
    end
  end

  // Sticky flags: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovFlag <= 1'b0;
      unFlag <= 1'b0;
    end else begin
      if (pushReq && full) ovFlag <= 1'b1;
      else if (statWr && regWrData[STAT_OV_BIT]) ovFlag <= 1'b0;
      if (popReq && empty) unFlag <= 1'b1;
      else if (statWr && regWrData[STAT_UN_BIT]) unFlag <= 1'b0;
    end
  end

  always_comb begin
    readMux = '0;
    case (addrSel)
      ADDR_DATA: readMux[SAMPLE_W-1:0] = busPopValue;
      ADDR_CTRL: begin
        readMux[CTRL_HALF_BIT] = halfEn;
        readMux[CTRL_CH_LSB +: CH_W] = chanCount;
      end
      ADDR_STAT: begin
        readMux[STAT_FILL_LSB +: FILL_W] = frameFill;
        readMux[STAT_OV_BIT] = ovFlag;
        readMux[STAT_UN_BIT] = unFlag;
      end
      default: readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (regRdEn) regRdData <= readMux;
  end

  assign halfLevel = FILL_W'(chanDepth(SLOTS, chanCount) / 2);
  assign irq = halfEn && (IS_TX ? (frameFill <= halfLevel) : (frameFill >= halfLevel));
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import asf_pkg::*;
#(
  parameter int SLOTS = 256,
  parameter bit IS_TX = 1'b1,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic              serReq,
  input  logic [23:0]       serIn,
  output logic [23:0]       serOut,
  output logic              irq
);
  localparam int FILL_W = $clog2(SLOTS + 1);

  fifoCmd_t cmd;
  logic dpFull, dpEmpty;
  logic [SAMPLE_W-1:0] headData;
  logic [FILL_W-1:0] frameFill;
  logic [CH_W-1:0] chanCount;
  logic halfEn, ovFlag, unFlag;

  asf_control #(.SLOTS(SLOTS), .IS_TX(IS_TX), .BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .serReq(serReq), .serIn(serIn), .serOut(serOut),
    .full(dpFull), .empty(dpEmpty), .headData(headData), .frameFill(frameFill),
    .cmd(cmd), .chanCount(chanCount), .halfEn(halfEn),
    .ovFlag(ovFlag), .unFlag(unFlag), .irq(irq)
  );

  asf_datapath #(.SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .chanCount(chanCount),
    .headData(headData), .frameFill(frameFill), .full(dpFull), .empty(dpEmpty)
  );
endmodule

// File: rtl/asf_checker.sv
module asf_checker
  import asf_pkg::*;
#(
  parameter int SLOTS = 256,
  parameter bit IS_TX = 1'b1
) (
  input logic                        clk,
  input logic                        rstN,
  input fifoCmd_t                    cmd,
  input logic                        full,
  input logic                        empty,
  input logic [$clog2(SLOTS+1)-1:0]  frameFill,
  input logic [CH_W-1:0]             chanCount,
  input logic                        unFlag,
  input logic                        serReq,
  input logic [23:0]                 serOut
);
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(frameFill) <= int'(chanDepth(SLOTS, chanCount)));

  p_push_not_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> !full);

  p_underrun_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (IS_TX && serReq && empty) |=> (serOut == 24'd0 && unFlag));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> (frameFill == '0 && empty));

  p_chan_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    (chanCount >= 4'd1) && (int'(chanCount) <= MAX_CH));
endmodule

bind audio_sample_fifo asf_checker #(.SLOTS(SLOTS), .IS_TX(IS_TX)) u_chk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .full(dpFull), .empty(dpEmpty),
  .frameFill(frameFill), .chanCount(chanCount), .unFlag(unFlag),
  .serReq(serReq), .serOut(serOut)
);

// File: tb/audio_sample_fifo_tb.sv
module audio_sample_fifo_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] wrEn, rdEn, sReq, irqV;
  logic [1:0][1:0] addr;
  logic [1:0][31:0] wData, rData;
  logic [1:0][23:0] sIn, sOut;

  audio_sample_fifo #(.IS_TX(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn[0]), .regRdEn(rdEn[0]), .regAddr(addr[0]),
    .regWrData(wData[0]), .regRdData(rData[0]), .serReq(sReq[0]), .serIn(sIn[0]),
    .serOut(sOut[0]), .irq(irqV[0]));

  audio_sample_fifo #(.IS_TX(1'b0)) u_dutRx (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn[1]), .regRdEn(rdEn[1]), .regAddr(addr[1]),
    .regWrData(wData[1]), .regRdData(rData[1]), .serReq(sReq[1]), .serIn(sIn[1]),
    .serOut(sOut[1]), .irq(irqV[1]));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [23:0] q0[$];
  logic [23:0] q1[$];
  int chanM[2];
  bit ovM[2], unM[2], halfM[2];

  function automatic int depthOf(int ch);
    if (ch == 1) return 256;
    if (ch == 2) return 128;
    if (ch <= 4) return 64;
    return 32;
  endfunction

  function automatic int qSize(int d);
    return (d == 0) ? q0.size() : q1.size();
  endfunction

  function automatic void qFlush(int d);
    if (d == 0) q0.delete(); else q1.delete();
  endfunction

  function automatic void modelPush(int d, logic [23:0] v);
    if (qSize(d) >= depthOf(chanM[d]) * chanM[d]) ovM[d] = 1'b1;
    else if (d == 0) q0.push_back(v);
    else q1.push_back(v);
  endfunction

  function automatic logic [23:0] modelPop(int d);
    if (qSize(d) == 0) begin
      unM[d] = 1'b1;
      return 24'd0;
    end
    if (d == 0) return q0.pop_front();
    return q1.pop_front();
  endfunction

  function automatic int fillOf(int d);
    return qSize(d) / chanM[d];
  endfunction

  function automatic logic [31:0] statusOf(int d);
    return (32'(fillOf(d)) << 8) | (32'(ovM[d]) << 4) | 32'(unM[d]);
  endfunction

  function automatic bit irqOf(int d);
    int half = depthOf(chanM[d]) / 2;
    if (!halfM[d]) return 1'b0;
    return (d == 0) ? (fillOf(d) <= half) : (fillOf(d) >= half);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(int d, logic [1:0] a, logic [31:0] v);
    wrEn[d] = 1'b1; addr[d] = a; wData[d] = v;
    @(negedge clk);
    wrEn[d] = 1'b0;
  endtask

  task automatic busRead(int d, logic [1:0] a, output logic [31:0] v);
    rdEn[d] = 1'b1; addr[d] = a;
    @(negedge clk);
    rdEn[d] = 1'b0;
    v = rData[d];
  endtask

  task automatic serialOp(int d, logic [23:0] v, output logic [23:0] o);
    sReq[d] = 1'b1; sIn[d] = v;
    @(negedge clk);
    sReq[d] = 1'b0;
    o = sOut[d];
  endtask

  task automatic checkIrq(int d, string tag);
    check(irqV[d] == irqOf(d), tag, 32'(irqV[d]), 32'(irqOf(d)));
  endtask

  task automatic pushOp(int d, logic [31:0] v);
    logic [23:0] o;
    modelPush(d, v[23:0]);
    if (d == 0) busWrite(0, 2'd0, v);
    else serialOp(1, v[23:0], o);
    checkIrq(d, "R10 irq after push");
  endtask

  task automatic popOp(int d, string tag);
    logic [23:0] exp, got;
    logic [31:0] w;
    exp = modelPop(d);
    if (d == 0) serialOp(0, 24'd0, got);
    else begin
      busRead(1, 2'd0, w);
      got = w[23:0];
      check(w[31:24] == 8'd0, "R2 upper bits zero", w, 32'(exp));
    end
    check(got == exp, tag, 32'(got), 32'(exp));
    checkIrq(d, "R10 irq after pop");
  endtask

  task automatic checkStatus(int d, string tag);
    logic [31:0] v;
    busRead(d, 2'd2, v);
    check(v == statusOf(d), tag, v, statusOf(d));
  endtask

  task automatic checkCtrl(int d, string tag);
    logic [31:0] v, e;
    e = (32'(halfM[d]) << 20) | (32'(chanM[d]) << 8);
    busRead(d, 2'd1, v);
    check(v == e, tag, v, e);
  endtask

  task automatic writeCtrl(int d, logic [31:0] v);
    int c = int'(v[11:8]);
    halfM[d] = v[20];
    if (c >= 1 && c <= 8 && c != chanM[d]) begin
      chanM[d] = c;
      qFlush(d);
    end
    if (v[0]) qFlush(d);
    busWrite(d, 2'd1, v);
    checkIrq(d, "R10 irq after control write");
  endtask

  task automatic clearFlags(int d, logic [31:0] v);
    if (v[4]) ovM[d] = 1'b0;
    if (v[0]) unM[d] = 1'b0;
    busWrite(d, 2'd2, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    wrEn = '0; rdEn = '0; sReq = '0; addr = '0; wData = '0; sIn = '0;
    for (int d = 0; d < 2; d++) begin
      chanM[d] = 1; ovM[d] = 0; unM[d] = 0; halfM[d] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int d = 0; d < 2; d++) begin
      checkStatus(d, "R1 status after reset");
      checkCtrl(d, "R1 control after reset");
      checkIrq(d, "R1 irq after reset");
    end

    // R2 upper byte dropped, 16-bit sample layout kept
    pushOp(0, 32'hA512_3456);
    pushOp(0, 32'h00AB_CD00);
    popOp(0, "R2 low 24 bits kept");
    popOp(0, "R2 16-bit sample layout");

    // R6 underflow returns zero, R7 sticky then write-1 clear
    popOp(0, "R6 empty pop returns zero");
    checkStatus(0, "R6 underflow flag set");
    clearFlags(0, 32'h10);
    checkStatus(0, "R7 flag kept when its bit written 0");
    clearFlags(0, 32'h01);
    checkStatus(0, "R7 underflow cleared by write 1");

    // R4/R5/R3 capacity with 3 channels (64 per channel, 192 samples)
    writeCtrl(0, 32'h0010_0300);
    checkCtrl(0, "R11 channel count 3 taken");
    for (int i = 0; i < 192; i++) pushOp(0, $urandom);
    checkStatus(0, "R4 full at 3 channels");
    pushOp(0, 32'h0000_0BAD);
    checkStatus(0, "R5 overflow flagged, sample dropped");
    for (int i = 0; i < 192; i++) popOp(0, "R3 order preserved");
    checkStatus(0, "R4 drained");
    clearFlags(0, 32'h11);

    // R8 partial frame, R11 illegal counts ignored, change flushes
    for (int i = 0; i < 4; i++) pushOp(0, $urandom);
    checkStatus(0, "R8 four samples at 3 channels is one frame");
    writeCtrl(0, 32'h0000_0900);
    checkCtrl(0, "R11 count 9 ignored");
    checkStatus(0, "R11 illegal count keeps contents");
    writeCtrl(0, 32'h0000_0000);
    checkCtrl(0, "R11 count 0 ignored");
    writeCtrl(0, 32'h0000_0500);
    checkStatus(0, "R11 count change flushes");
    for (int i = 0; i < 161; i++) pushOp(0, $urandom);
    checkStatus(0, "R4 full at 5 channels with overflow");
    clearFlags(0, 32'h10);

    // R9 flush with unchanged count
    writeCtrl(0, 32'h0000_0501);
    checkStatus(0, "R9 flush empties store");
    popOp(0, "R9 pop after flush sees empty");
    clearFlags(0, 32'h01);

    // R10 receive direction half threshold at 2 channels (half = 64 frames)
    writeCtrl(1, 32'h0010_0200);
    for (int i = 0; i < 127; i++) pushOp(1, $urandom);
    checkIrq(1, "R10 receive irq low below half");
    pushOp(1, $urandom);
    checkIrq(1, "R10 receive irq high at half");
    checkStatus(1, "R8 receive fill 64 frames");
    for (int i = 0; i < 128; i++) popOp(1, "R3 receive order preserved");
    popOp(1, "R6 receive empty read returns zero");
    checkStatus(1, "R6 receive underflow flag");

    // Random mix on both directions
    for (int i = 0; i < 4000; i++) begin
      int d = int'($urandom % 2);
      int op = int'($urandom % 20);
      if (op < 10) pushOp(d, $urandom);
      else if (op < 16) popOp(d, "R3 random pop");
      else if (op < 18) checkStatus(d, "R8 random status");
      else if (op == 18) clearFlags(d, $urandom & 32'h11);
      else if ($urandom % 4 == 0) begin
        logic [31:0] v;
        v = (32'($urandom % 11) << 8) | (32'($urandom % 2) << 20) | 32'(($urandom % 4) == 0);
        writeCtrl(d, v);
        checkCtrl(d, "R11 random control readback");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule